// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Periodic Timer

This block keeps wall time and produces timed interrupts. A 40-bit counter advances once for each pulse of a slow tick enable, nominally one every 30.517 µs from a 32.768 kHz time base. At that rate it runs about 388 days before it wraps. A 40-bit alarm value is compared against the counter, and an interrupt is flagged when the counter steps onto it. A 16-bit periodic timer is driven by a separate fast tick, nominally 0.868 µs, which gives periods up to about 56.8 ms. A third interrupt warns software when the counter is nearing roll-over.

Software reaches the block through a flat register port with one-cycle write and read strobes, a 3-bit word address and combinational read data. The port has no back-pressure: each strobe takes effect in the cycle it is asserted. Values wider than 32 bits are handled in two parts. For a write, the upper part is staged first and the low-word write commits the whole value. For a read, reading the low word takes a snapshot of the upper byte, so the two halves always come from one count. Three status bits are sticky and are cleared by writing 1. Each status bit reaches its own interrupt pin through a mask bit.

Register map (word address): 0 counter low, 1 counter high, 2 alarm low, 3 alarm high, 4 timer, 5 status, 6 mask. Status and mask bits: 0 alarm, 1 timer, 2 roll-over warning.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset the counter, alarm, status and mask all read as zero, and the three interrupt outputs are low.
- R2: The counter increases by exactly one on each cycle where `tick_slow` is high and no counter load occurs. It holds its value in all other cycles.
- R3: A write to address 1 stages bits [7:0] as the counter's upper byte. A following write to address 0 loads the counter with {staged byte, wdata}. A load takes priority over a tick in the same cycle.
- R4: A read of address 0 returns counter bits [31:0] and latches counter bits [39:32]. A read of address 1 returns that latched byte in bits [7:0] even if the counter has advanced since.
- R5: Status bit 0 sets when a tick advances the counter onto the alarm value. The alarm is written by staging bits [7:0] at address 3 and committing with a write to address 2.
- R6: Loading the counter with a value equal to the alarm does not set status bit 0.
- R7: A write to address 4 sets the timer reload value and current count from wdata[15:0]. With a nonzero reload the count decreases by one on each `tick_fast`. On a tick at zero it reloads and sets status bit 1, so it expires every reload+1 ticks. A zero reload stops the timer. A read of address 4 returns {count, reload}.
- R8: Status bit 2 sets on the tick that first makes counter bits [39:32] all ones. It does not set again while they stay all ones.
- R9: Writing 1 to a bit of address 5 clears that status bit. Bits written with 0 are kept. A set event in the same cycle as the clear wins.
- R10: Each interrupt output (`irq_alarm`, `irq_timer`, `irq_roll`) is the AND of its status bit and the matching bit of the mask at address 6.
- R11: A tick at counter value 2^40-1 wraps the counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_slow | input | 1 | One-cycle enable advancing the 40-bit counter |
| tick_fast | input | 1 | One-cycle enable advancing the periodic timer |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives the snapshot) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq_alarm | output | 1 | Masked alarm interrupt |
| irq_timer | output | 1 | Masked periodic timer interrupt |
| irq_roll | output | 1 | Masked roll-over warning interrupt |

## Verification
A counter that skips or repeats a count shows up on the next low-word read. A wrong carry into the upper byte shows up on the next snapshot read of address 1, so a torn snapshot is visible one read after the tick that crosses a 32-bit boundary. An alarm or roll-over comparator that looks at the wrong value sets its status bit one tick early or late, or sets it on a load. The sticky status makes any stray set visible at the first status read that follows. A timer off by one expires one fast tick early or late against the count reported at address 4.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CNT_W  = 40;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TMR_W  = 16;
  localparam int unsigned WARN_W = 8;
  localparam int unsigned NSTAT  = 3;

  typedef enum logic [2:0] {
    A_CNT_LO = 3'd0,
    A_CNT_HI = 3'd1,
    A_ALM_LO = 3'd2,
    A_ALM_HI = 3'd3,
    A_TMR    = 3'd4,
    A_STAT   = 3'd5,
    A_MASK   = 3'd6
  } reg_addr_e;

  localparam int unsigned S_ALARM = 0;
  localparam int unsigned S_TIMER = 1;
  localparam int unsigned S_ROLL  = 2;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned CW = 40,
  parameter int unsigned WB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_inc,
  output logic          adv,
  output logic          roll_hit
);
  assign cnt_inc  = cnt + 1'b1;
  assign adv      = tick && !load;
  assign roll_hit = adv && (&cnt_inc[CW-1 -: WB]) && !(&cnt[CW-1 -: WB]);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt_inc;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
  p_roll_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    roll_hit |=> (&cnt[CW-1 -: WB]));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned CW = 40,
  parameter int unsigned LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_we,
  input  logic          commit_we,
  input  logic [LW-1:0] wdata,
  input  logic          adv,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_inc,
  output logic [CW-1:0] alarm,
  output logic          hit
);
  localparam int unsigned HW = CW - LW;
  logic [HW-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      alarm   <= '0;
    end else begin
      if (stage_we)  stage_q <= wdata[HW-1:0];
      if (commit_we) alarm   <= {stage_q, wdata};
    end
  end

  assign hit = adv && (cnt_inc == alarm);

  p_no_load_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |-> !hit);
endmodule

// File: rtl/rtc_ptimer.sv
module rtc_ptimer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [TW-1:0] wval,
  output logic [TW-1:0] count,
  output logic [TW-1:0] reload,
  output logic          expire
);
  logic running;
  assign running = (reload != '0);
  assign expire  = tick && running && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
    end else if (wr) begin
      count  <= wval;
      reload <= wval;
    end else if (tick && running) begin
      count <= (count == '0) ? reload : count - 1'b1;
    end
  end

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr) |=> (count == reload));
  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned LW = WORD_W,
  parameter int unsigned TW = TMR_W,
  parameter int unsigned WB = WARN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_slow,
  input  logic          tick_fast,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_alarm,
  output logic          irq_timer,
  output logic          irq_roll
);
  localparam int unsigned HW = CW - LW;

  logic [CW-1:0] cnt, cnt_inc, alarm;
  logic [HW-1:0] cnt_stage, snap;
  logic [TW-1:0] t_count, t_reload;
  logic          adv, roll_hit, alm_hit, t_exp, cnt_load;
  logic [NSTAT-1:0] stat, mask, set_v, clr_v;

  function automatic logic wr_at(input logic [2:0] a, input reg_addr_e r);
    return reg_wr && (a == r);
  endfunction

  assign cnt_load = wr_at(reg_addr, A_CNT_LO);

  rtc_counter #(.CW(CW), .WB(WB)) u_cnt (
    .clk, .rst_n, .tick(tick_slow), .load(cnt_load),
    .load_val({cnt_stage, reg_wdata[LW-1:0]}),
    .cnt, .cnt_inc, .adv, .roll_hit
  );

  rtc_alarm #(.CW(CW), .LW(LW)) u_alm (
    .clk, .rst_n,
    .stage_we(wr_at(reg_addr, A_ALM_HI)),
    .commit_we(wr_at(reg_addr, A_ALM_LO)),
    .wdata(reg_wdata[LW-1:0]),
    .adv, .cnt_load, .cnt_inc, .alarm, .hit(alm_hit)
  );

  rtc_ptimer #(.TW(TW)) u_tmr (
    .clk, .rst_n, .tick(tick_fast),
    .wr(wr_at(reg_addr, A_TMR)), .wval(reg_wdata[TW-1:0]),
    .count(t_count), .reload(t_reload), .expire(t_exp)
  );

  always_comb begin
    set_v = '0;
    set_v[S_ALARM] = alm_hit;
    set_v[S_TIMER] = t_exp;
    set_v[S_ROLL]  = roll_hit;
    clr_v = wr_at(reg_addr, A_STAT) ? reg_wdata[NSTAT-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_stage <= '0;
      snap      <= '0;
      stat      <= '0;
      mask      <= '0;
    end else begin
      if (wr_at(reg_addr, A_CNT_HI)) cnt_stage <= reg_wdata[HW-1:0];
      if (wr_at(reg_addr, A_MASK))   mask      <= reg_wdata[NSTAT-1:0];
      if (reg_rd && reg_addr == A_CNT_LO) snap <= cnt[CW-1:LW];
      stat <= (stat & ~clr_v) | set_v;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CNT_LO: reg_rdata = cnt[LW-1:0];
      A_CNT_HI: reg_rdata[HW-1:0] = snap;
      A_ALM_LO: reg_rdata = alarm[LW-1:0];
      A_ALM_HI: reg_rdata[HW-1:0] = alarm[CW-1:LW];
      A_TMR:    reg_rdata = {t_count, t_reload};
      A_STAT:   reg_rdata[NSTAT-1:0] = stat;
      A_MASK:   reg_rdata[NSTAT-1:0] = mask;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_alarm = stat[S_ALARM] & mask[S_ALARM];
  assign irq_timer = stat[S_TIMER] & mask[S_TIMER];
  assign irq_roll  = stat[S_ROLL]  & mask[S_ROLL];

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[S_ALARM] && !clr_v[S_ALARM]) |=> stat[S_ALARM]);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit |=> stat[S_ALARM]);
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mask[S_ROLL] |-> !irq_roll);
endmodule

// File: tb/rtc_alarm_top_bench.sv
module rtc_alarm_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_slow = 1'b0, tick_fast = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_alarm, irq_timer, irq_roll;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_v[$];
  string       exp_tag[$];

  always #2 clk = ~clk;

  rtc_alarm_top u_rtc_alarm_top (
    .clk, .rst_n, .tick_slow, .tick_fast, .reg_wr, .reg_rd, .reg_addr,
    .reg_wdata, .reg_rdata, .irq_alarm, .irq_timer, .irq_roll
  );

  // monitor: pop expected read data and compare
  always @(negedge clk) begin
    if (rst_n && reg_rd) begin
      checks++;
      if (exp_v.size() == 0) begin
        fails++;
        $display("FAIL unexpected read got=%h exp=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_v.pop_front();
        t = exp_tag.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s got=%h exp=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic op(input logic w, input logic r, input logic [2:0] a,
                    input logic [31:0] d, input logic ts, input logic tf);
    @(posedge clk); #1;
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    tick_slow = ts; tick_fast = tf;
    @(posedge clk); #1;
    reg_wr = 0; reg_rd = 0; tick_slow = 0; tick_fast = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    op(1, 0, a, d, 0, 0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_v.push_back(e);
    exp_tag.push_back(t);
    op(0, 1, a, '0, 0, 0);
  endtask

  task automatic ts();
    op(0, 0, 0, '0, 1, 0);
  endtask

  task automatic tf();
    op(0, 0, 0, '0, 0, 1);
  endtask

  task automatic chk(input logic got, input logic e, input string t);
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b", t, got, e);
    end
  endtask

  task automatic finish_run();
    if (exp_v.size() != 0) begin
      fails++;
      $display("FAIL scoreboard left=%0d exp=0", exp_v.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rd(0, 32'h0, "R1 cnt_lo");
    rd(2, 32'h0, "R1 alarm");
    rd(5, 32'h0, "R1 stat");
    rd(6, 32'h0, "R1 mask");
    chk(irq_alarm | irq_timer | irq_roll, 1'b0, "R1 irq");

    // R2 counting
    ts(); ts(); ts();
    repeat (4) @(posedge clk);
    rd(0, 32'd3, "R2 three ticks");

    // R3 load, and load wins over tick
    wr(1, 32'h12);
    wr(0, 32'h3456789A);
    rd(0, 32'h3456789A, "R3 load lo");
    rd(1, 32'h12, "R3 load hi");
    op(1, 0, 0, 32'h00000010, 1, 0);
    rd(0, 32'h10, "R3 load beats tick");

    // R4 snapshot across carry
    wr(1, 32'h0);
    wr(0, 32'hFFFFFFFF);
    rd(0, 32'hFFFFFFFF, "R4 lo before carry");
    ts();
    rd(1, 32'h0, "R4 snapshot held");
    rd(0, 32'h0, "R4 lo after carry");
    rd(1, 32'h1, "R4 snapshot updated");

    // R5 R6 alarm
    wr(6, 32'h7);
    wr(3, 32'h0);
    wr(2, 32'd100);
    rd(2, 32'd100, "R5 alarm lo");
    wr(1, 32'h0);
    wr(0, 32'd100);
    rd(5, 32'h0, "R6 load equal no match");
    chk(irq_alarm, 1'b0, "R6 irq");
    wr(0, 32'd99);
    ts();
    rd(5, 32'h1, "R5 alarm set");
    chk(irq_alarm, 1'b1, "R10 irq_alarm on");
    wr(6, 32'h6);
    chk(irq_alarm, 1'b0, "R10 masked");
    wr(6, 32'h7);
    wr(5, 32'h2);
    rd(5, 32'h1, "R9 write0 keeps");
    wr(5, 32'h1);
    rd(5, 32'h0, "R9 w1c");

    // R9 set wins over clear
    wr(0, 32'd99);
    op(1, 0, 5, 32'h1, 1, 0);
    rd(5, 32'h1, "R9 set wins");
    wr(5, 32'h7);

    // R8 roll warning
    wr(1, 32'hFE);
    wr(0, 32'hFFFFFFFF);
    rd(5, 32'h0, "R8 none before");
    ts();
    rd(5, 32'h4, "R8 warn set");
    chk(irq_roll, 1'b1, "R10 irq_roll");
    wr(5, 32'h4);
    ts();
    rd(5, 32'h0, "R8 no repeat");

    // R11 wrap
    wr(1, 32'hFF);
    wr(0, 32'hFFFFFFFF);
    ts();
    rd(0, 32'h0, "R11 wrap lo");
    rd(1, 32'h0, "R11 wrap hi");
    rd(5, 32'h0, "R8 no warn at wrap");

    // R7 periodic timer
    wr(4, 32'd3);
    rd(4, {16'd3, 16'd3}, "R7 loaded");
    tf(); tf();
    rd(4, {16'd1, 16'd3}, "R7 count down");
    tf();
    rd(5, 32'h0, "R7 not yet");
    tf();
    rd(5, 32'h2, "R7 expired");
    chk(irq_timer, 1'b1, "R10 irq_timer");
    rd(4, {16'd3, 16'd3}, "R7 reloaded");
    wr(5, 32'h2);
    tf(); tf(); tf(); tf();
    rd(5, 32'h2, "R7 second period");
    wr(5, 32'h2);
    wr(4, 32'd0);
    repeat (6) tf();
    rd(5, 32'h0, "R7 zero stops");
    rd(4, 32'h0, "R7 zero count");

    finish_run();
  end
endmodule